// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two operand words over several clock cycles. A start request in the idle state captures the multiplicand, the multiplier and a signedness select. A Moore controller then loads the working registers and walks the recoded multiplier two bits at a time. Each recoded digit takes a value in the set {-2, -1, 0, +1, +2}. For every digit but the last, the controller picks one of three actions: add then shift, subtract then shift, or shift only. The final digit is handled by an add-only or subtract-only step, which is followed by a single completion state. A final digit of zero skips straight to that completion state. The accumulator moves right by two bit positions per shifted step. The product appears as a slice of the accumulator and multiplier registers.

Unsigned operands have two zero bits appended above the multiplier, so one more digit is examined than in signed mode. A digit of magnitude two uses the multiplicand moved one place to the left. A library option selects how that doubled value is formed: on the fly, or from a register loaded once.

Top module: `booth4_mul`

## Requirements
- R1: With `signed_mode` = 0, the `product` shown while `done` is high equals the unsigned product of the captured operands, all 2*WIDTH bits.
- R2: With `signed_mode` = 1, the operands are read as two's complement and `product` equals their 2*WIDTH-bit two's complement product.
- R3: `done` is high for exactly one cycle per accepted start. It is low in every other cycle, and the controller is idle in the cycle after `done`.
- R4: Let N be WIDTH/2 digits in signed mode and WIDTH/2+1 digits in unsigned mode. When the last digit is nonzero, `done` is high in the cycle that follows the (N+1)th rising edge after the edge that accepts `start`.
- R5: The last digit is zero when `mplier` bits [WIDTH-1:WIDTH-3] are all equal (signed mode), or when `mplier` bit WIDTH-1 is 0 (unsigned mode). In that case no final add or subtract step is taken, and `done` comes one cycle earlier than in R4.
- R6: `start` is accepted only in the idle state. A `start` seen during a computation, including the cycle in which `done` is high, is ignored. Operand and mode inputs may change freely after acceptance without affecting the result.
- R7: `product` keeps its value from the cycle `done` is high until the next `start` is accepted.
- R8: After reset, `done` is 0 and `product` is 0.
- R9: Extreme operands give exact results: all ones times all ones unsigned, and most-negative times most-negative, most-negative times most-positive, and most-positive times most-negative signed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests a multiplication; sampled only when idle |
| signed_mode | input | 1 | 1: two's complement operands, 0: unsigned operands |
| mcand | input | WIDTH | Multiplicand |
| mplier | input | WIDTH | Multiplier, Booth-recoded in pairs of bits |
| product | output | 2*WIDTH | Result, valid while `done` is high and held afterwards |
| done | output | 1 | High for the single cycle spent in the completion state |

## Verification
The bench builds two copies of the block side by side.

The first copy uses WIDTH = 16 with the doubled multiplicand formed on the fly. It runs directed extreme operands, patterns built from magnitude-two digits, multiplier tops that make the last digit zero or nonzero in both modes, and a long random run.

The second copy uses WIDTH = 6 with the registered doubled multiplicand. At that size every operand pair in both modes can be tried, which reaches every digit sequence and every latency variant of the three-digit and four-digit walks.

A behavioural model predicts the cycle of `done` and the product, and both are compared every cycle. Some runs raise `start` again while a computation is in progress.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ADD_SH,
      ST_SUB_SH,
      ST_SHIFT,
      ST_ADD_ONLY,
      ST_SUB_ONLY,
      ST_DONE
   } bmul_state_e;

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_LOAD,
      ACT_ADD,
      ACT_SUB
   } bmul_act_e;

   // window = {b[2i+1], b[2i], b[2i-1]}
   function automatic logic dig_zero(input logic [2:0] win);
      return (win == 3'b000) || (win == 3'b111);
   endfunction

   function automatic logic dig_neg(input logic [2:0] win);
      return win[2] && (win != 3'b111);
   endfunction

   function automatic logic dig_dbl(input logic [2:0] win);
      return (win == 3'b011) || (win == 3'b100);
   endfunction

endpackage

// File: rtl/booth4_ctrl.sv
module booth4_ctrl
   import booth4_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        mode_q,
   input  logic [2:0]  nxt_win,
   output bmul_act_e   act,
   output logic        shift_en,
   output logic        capture,
   output logic        done
);

   localparam int DIG_S = WIDTH / 2;
   localparam int DIG_U = WIDTH / 2 + 1;
   localparam int CW    = $clog2(DIG_U);

   bmul_state_e   state, state_nxt, pick;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last_idx;
   logic          next_last;
   logic          busy;

   assign last_idx  = mode_q ? CW'(DIG_S - 1) : CW'(DIG_U - 1);
   assign next_last = (state != ST_LOAD) && ((cnt + CW'(1)) == last_idx);

   always_comb begin
      if (next_last) begin
         if (dig_zero(nxt_win))     pick = ST_DONE;
         else if (dig_neg(nxt_win)) pick = ST_SUB_ONLY;
         else                       pick = ST_ADD_ONLY;
      end else begin
         if (dig_zero(nxt_win))     pick = ST_SHIFT;
         else if (dig_neg(nxt_win)) pick = ST_SUB_SH;
         else                       pick = ST_ADD_SH;
      end
   end

   always_comb begin
      state_nxt = state;
      unique case (state)
         ST_IDLE:                                    if (start) state_nxt = ST_LOAD;
         ST_LOAD, ST_ADD_SH, ST_SUB_SH, ST_SHIFT:    state_nxt = pick;
         ST_ADD_ONLY, ST_SUB_ONLY:                   state_nxt = ST_DONE;
         ST_DONE:                                    state_nxt = ST_IDLE;
         default:                                    state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= state_nxt;
         if (state == ST_LOAD)  cnt <= '0;
         else if (shift_en)     cnt <= cnt + CW'(1);
      end
   end

   // Moore outputs
   always_comb begin
      unique case (state)
         ST_LOAD:                 act = ACT_LOAD;
         ST_ADD_SH, ST_ADD_ONLY:  act = ACT_ADD;
         ST_SUB_SH, ST_SUB_ONLY:  act = ACT_SUB;
         default:                 act = ACT_NONE;
      endcase
   end

   assign shift_en = (state == ST_ADD_SH) || (state == ST_SUB_SH) || (state == ST_SHIFT);
   assign done     = (state == ST_DONE);
   assign busy     = (state != ST_IDLE);
   assign capture  = (state == ST_IDLE) && start;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> (!done && !busy)); // R3
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> (state != ST_LOAD)); // R6
   AST_ONLY_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n) ((state == ST_ADD_ONLY) || (state == ST_SUB_ONLY)) |-> (cnt == last_idx)); // R5
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (cnt <= CW'(DIG_U - 1))); // R4

endmodule

// File: rtl/booth4_datapath.sv
module booth4_datapath
   import booth4_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit PRE_DOUBLE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 capture,
   input  logic                 mode_in,
   input  logic [WIDTH-1:0]     mcand_in,
   input  logic [WIDTH-1:0]     mplier_in,
   input  bmul_act_e            act,
   input  logic                 shift_en,
   output logic                 mode_q,
   output logic [2:0]           nxt_win,
   output logic [2*WIDTH-1:0]   product
);

   localparam int HW = WIDTH + 3;   // accumulator, holds +-4*mcand
   localparam int LW = WIDTH + 2;   // multiplier with two extension bits

   logic [WIDTH-1:0] a_q, b_q;
   logic [HW-1:0]    mc_q, hi_q, addend, sum;
   logic [LW-1:0]    lo_q;
   logic             qm1_q;
   logic [HW-1:0]    a_ext;
   logic [LW-1:0]    b_ext;
   logic [2:0]       cur_win;

   assign a_ext   = mode_q ? {{3{a_q[WIDTH-1]}}, a_q} : {3'b000, a_q};
   assign b_ext   = mode_q ? {{2{b_q[WIDTH-1]}}, b_q} : {2'b00, b_q};
   assign cur_win = {lo_q[1:0], qm1_q};
   assign nxt_win = (act == ACT_LOAD) ? {b_q[1:0], 1'b0} : {lo_q[3:2], lo_q[1]};

   generate
      if (PRE_DOUBLE) begin : g_pre_double
         logic [HW-1:0] mc2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 mc2_q <= '0;
            else if (act == ACT_LOAD)   mc2_q <= {a_ext[HW-2:0], 1'b0};
         end
         assign addend = dig_dbl(cur_win) ? mc2_q : mc_q;
      end else begin : g_fly_double
         assign addend = dig_dbl(cur_win) ? {mc_q[HW-2:0], 1'b0} : mc_q;
      end
   endgenerate

   always_comb begin
      unique case (act)
         ACT_ADD: sum = hi_q + addend;
         ACT_SUB: sum = hi_q - addend;
         default: sum = hi_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= 1'b0;
         mc_q   <= '0;
         hi_q   <= '0;
         lo_q   <= '0;
         qm1_q  <= 1'b0;
      end else begin
         if (capture) begin
            a_q    <= mcand_in;
            b_q    <= mplier_in;
            mode_q <= mode_in;
         end
         if (act == ACT_LOAD) begin
            mc_q  <= a_ext;
            hi_q  <= '0;
            lo_q  <= b_ext;
            qm1_q <= 1'b0;
         end else if (shift_en) begin
            hi_q  <= {{2{sum[HW-1]}}, sum[HW-1:2]};
            lo_q  <= {sum[1:0], lo_q[LW-1:2]};
            qm1_q <= lo_q[1];
         end else if (act != ACT_NONE) begin
            hi_q  <= sum;
         end
      end
   end

   // final digit is added without a shift; the missing shift is taken here
   assign product = mode_q ? {hi_q[WIDTH+1:0], lo_q[LW-1:4]}
                           : {hi_q[WIDTH-1:0], lo_q[LW-1:2]};

   AST_ADD_MATCHES_DIGIT: assert property (@(posedge clk) disable iff (!rst_n) (act == ACT_ADD) |-> (!dig_zero(cur_win) && !dig_neg(cur_win))); // R1
   AST_SUB_MATCHES_DIGIT: assert property (@(posedge clk) disable iff (!rst_n) (act == ACT_SUB) |-> dig_neg(cur_win)); // R2
   AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((act == ACT_NONE) && !shift_en && !capture) |=> $stable(product)); // R7

endmodule

// File: rtl/booth4_mul.sv
module booth4_mul
   import booth4_pkg::*;
#(
   parameter int WIDTH      = 16,
   parameter bit PRE_DOUBLE = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 signed_mode,
   input  logic [WIDTH-1:0]     mcand,
   input  logic [WIDTH-1:0]     mplier,
   output logic [2*WIDTH-1:0]   product,
   output logic                 done
);

   generate
      if ((WIDTH % 2) != 0 || WIDTH < 4) begin : g_bad_width
         $error("booth4_mul: WIDTH must be even and at least 4");
      end
   endgenerate

   bmul_act_e  act;
   logic       shift_en;
   logic       capture;
   logic       mode_q;
   logic [2:0] nxt_win;

   booth4_ctrl #(
      .WIDTH (WIDTH)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .mode_q   (mode_q),
      .nxt_win  (nxt_win),
      .act      (act),
      .shift_en (shift_en),
      .capture  (capture),
      .done     (done)
   );

   booth4_datapath #(
      .WIDTH      (WIDTH),
      .PRE_DOUBLE (PRE_DOUBLE)
   ) u_datapath (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .mode_in   (signed_mode),
      .mcand_in  (mcand),
      .mplier_in (mplier),
      .act       (act),
      .shift_en  (shift_en),
      .mode_q    (mode_q),
      .nxt_win   (nxt_win),
      .product   (product)
   );

endmodule

// File: tb/booth4_mul_bench.sv
module booth4_lane #(
   parameter int W       = 16,
   parameter bit PRE     = 1'b0,
   parameter bit EXHAUST = 1'b0,
   parameter int NRAND   = 300
) (
   input  logic clk,
   input  logic rst_n,
   output int   n_chk,
   output int   n_err,
   output bit   fin
);

   logic           start, smode;
   logic [W-1:0]   a, b;
   logic [2*W-1:0] product;
   logic           done;

   booth4_mul #(.WIDTH(W), .PRE_DOUBLE(PRE)) u_booth4_mul (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(smode),
      .mcand(a), .mplier(b), .product(product), .done(done)
   );

   string          cur_tag = "R1";
   logic           exp_done;
   logic [2*W-1:0] exp_prod;
   bit             m_busy, have_res;
   int             m_cnt;

   function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] x, logic [W-1:0] y, logic m);
      longint px, py, pr;
      px = longint'(x);
      py = longint'(y);
      if (m && x[W-1]) px = px - (longint'(1) << W);
      if (m && y[W-1]) py = py - (longint'(1) << W);
      pr = px * py;
      return pr[2*W-1:0];
   endfunction

   function automatic int ref_lat(logic [W-1:0] y, logic m);
      int n;
      bit lz;
      n  = m ? W / 2 : W / 2 + 1;
      lz = m ? ((y[W-1] == y[W-2]) && (y[W-2] == y[W-3])) : !y[W-1];
      return lz ? n : n + 1;
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] act_v, logic [63:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s (W=%0d): actual %0h expected %0h", tag, W, act_v, exp_v);
      end
   endtask

   // reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_done = 1'b0; m_busy = 1'b0; m_cnt = 0; have_res = 1'b1; exp_prod = '0;
      end else if (exp_done) begin
         exp_done = 1'b0; m_busy = 1'b0;
      end else if (m_busy) begin
         m_cnt--;
         if (m_cnt == 0) exp_done = 1'b1;
      end else if (start) begin
         exp_prod = ref_mul(a, b, smode);
         m_cnt    = ref_lat(b, smode);
         m_busy   = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(done === exp_done, {"R3/R4 done timing, op ", cur_tag}, 64'(done), 64'(exp_done));
         if (exp_done)
            chk(product === exp_prod, {cur_tag, " product"}, 64'(product), 64'(exp_prod));
         else if (!m_busy && have_res)
            chk(product === exp_prod, "R7 product hold", 64'(product), 64'(exp_prod));
      end
   end

   task automatic run_op(logic [W-1:0] x, logic [W-1:0] y, logic m, string tag, bit poke, int gap);
      @(negedge clk);
      cur_tag = tag; start = 1'b1; a = x; b = y; smode = m;
      @(negedge clk);
      start = poke; a = W'($urandom); b = W'($urandom); smode = ~m;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      if (poke) begin
         start = 1'b1; a = W'($urandom); b = W'($urandom);
         @(negedge clk);
         start = 1'b0;
      end
      repeat (gap) @(negedge clk);
   endtask

   initial begin
      n_chk = 0; n_err = 0; fin = 1'b0;
      start = 1'b0; smode = 1'b0; a = '0; b = '0;
      wait (rst_n === 1'b1);
      @(negedge clk);
      chk((done === 1'b0) && (product === '0), "R8 reset state", 64'(product), 64'(0));
      if (EXHAUST) begin
         for (int m = 0; m < 2; m++)
            for (int x = 0; x < (1 << W); x++)
               for (int y = 0; y < (1 << W); y++)
                  run_op(W'(x), W'(y), m[0], (m != 0) ? "R2" : "R1", ((x + y) % 5) == 0, 0);
      end else begin
         logic [W-1:0] mn, mx, ones;
         mn = '0; mn[W-1] = 1'b1; mx = ~mn; ones = '1;
         run_op(ones, ones, 1'b0, "R9", 0, 1);
         run_op(mn, mn, 1'b1, "R9", 0, 0);
         run_op(mn, mx, 1'b1, "R9", 0, 2);
         run_op(mx, mn, 1'b1, "R9", 0, 0);
         run_op(ones, ones, 1'b1, "R2", 0, 1);
         run_op('0, W'(16'h1234), 1'b0, "R1", 0, 0);
         run_op(W'(16'h1234), '0, 1'b1, "R2", 0, 0);
         run_op(W'(16'h5A5A), W'(16'h3333), 1'b0, "R1", 0, 1);
         run_op(W'(16'hA5A5), W'(16'hCCCC), 1'b1, "R2", 0, 0);
         run_op(W'(16'h00AB), W'(16'h1234), 1'b1, "R5", 0, 0);
         run_op(W'(16'h00AB), W'(16'hE123), 1'b1, "R5", 0, 1);
         run_op(W'(16'h00AB), W'(16'hA123), 1'b1, "R5", 0, 0);
         run_op(W'(16'h00AB), W'(16'h7FFF), 1'b0, "R5", 0, 0);
         run_op(W'(16'h00AB), W'(16'h8001), 1'b0, "R5", 0, 2);
         run_op(W'(16'h1357), W'(16'h2468), 1'b0, "R6", 1, 0);
         run_op(W'(16'hF357), W'(16'h9468), 1'b1, "R6", 1, 3);
         for (int i = 0; i < NRAND; i++) begin
            logic rm;
            rm = 1'($urandom);
            run_op(W'($urandom), W'($urandom), rm, rm ? "R2" : "R1", ($urandom % 4) == 0, $urandom % 3);
         end
      end
      repeat (3) @(negedge clk);
      fin = 1'b1;
   end

endmodule

module booth4_mul_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   c16, e16, c6, e6;
   bit   f16, f6;
   int   cyc = 0;

   always #4 clk = ~clk;   // 125 MHz

   always @(posedge clk) cyc++;

   booth4_lane #(.W(16), .PRE(1'b0), .EXHAUST(1'b0), .NRAND(300)) u_lane16 (
      .clk(clk), .rst_n(rst_n), .n_chk(c16), .n_err(e16), .fin(f16)
   );

   booth4_lane #(.W(6), .PRE(1'b1), .EXHAUST(1'b1), .NRAND(0)) u_lane6 (
      .clk(clk), .rst_n(rst_n), .n_chk(c6), .n_err(e6), .fin(f6)
   );

   initial begin
      int tot_chk, tot_err;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      wait ((f16 && f6) || (cyc >= 190000));
      tot_chk = c16 + c6;
      tot_err = e16 + e6;
      if (!(f16 && f6)) begin
         tot_chk++;
         tot_err++;
         $display("FAIL watchdog: run did not complete, actual cycles %0d expected fewer than %0d", cyc, 190000);
      end
      $display("Simulation finished: %0d checks, %0d errors", tot_chk, tot_err);
      $finish;
   end

endmodule